// File: doc/BRIEF.md
# Interval Down-Counter with Split Register Access

This block is a down-counting interval timer of configurable width, normally 32 bits, that software controls over a narrow synchronous register bus of half the counter width. Software writes the reload value in two halves. It then sets a run bit. The counter loads the reload value on that start and decrements once per enabled tick. Whenever the count passes through zero, the block raises a single-cycle event output.

In one-shot mode, the block clears the run bit on its own when the count passes through zero, and the counter then rests at zero. In periodic mode, the counter takes the reload value again and keeps going, so the period is the reload value plus one ticks. Software reads the live count in two halves. Reading the upper half first freezes the matching lower half, so the two reads always describe one coherent value.

Top module: `itmr_interval_timer`

## Requirements
- R1: After reset, the control register reads 0 (stopped, one-shot), both count halves read 0 and `zero_evt` is low.
- R2: The control register is at offset 0x0. Bit 0 is run (1 counts, 0 halts) and bit 1 is mode (0 one-shot, 1 periodic). Both bits read back at the same positions and all other bits read 0.
- R3: The reload value is written at offset 0x4 (bits 15:0) and offset 0x6 (bits 31:16). These writes never change the current count, and reads of both offsets return 0.
- R4: A control write that takes run from 0 to 1 loads the reload value into the counter. The new count is visible from the next cycle.
- R5: The count drops by one in each cycle in which run is 1, `tick_en` is high, no control write occurs and the count is non-zero. In every other cycle without a load, the count holds.
- R6: A counting cycle (run 1, `tick_en` high, no control write) that finds the count at zero drives `zero_evt` high for exactly the following cycle. This holds in both modes.
- R7: In one-shot mode, that zero cycle clears run to 0 and the count stays at 0.
- R8: In periodic mode, that zero cycle reloads the count from the reload value and run stays 1.
- R9: Writing 1 to run while run is already 1 does not reload the counter. The count holds for that cycle.
- R10: A read at offset 0xA returns count bits 31:16 in the same cycle and captures bits 15:0 at that moment. A read at offset 0x8 returns the captured bits, not the live count.
- R11: `bus_rdata` is combinational. It is 0 whenever `bus_rd` is low and for a read of any offset other than 0x0, 0x8 and 0xA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 4 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | CNT_W/2 | Write data |
| bus_rdata | output | CNT_W/2 | Read data, same cycle as `bus_rd` |
| tick_en | input | 1 | Count enable for this cycle |
| zero_evt | output | 1 | One-cycle pulse after the count passes through zero |

## Verification
The bench builds the block with the default 32-bit count, so the bus halves are 16 bits wide. It uses one reload value whose lower half sits just above zero with the upper half set. A few ticks then carry the count across the boundary between the halves, and this is where the frozen lower half differs from the live one. Small reload values, including zero, bring one-shot termination, back-to-back periodic events and restart behaviour within a few hundred cycles.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_LD_LO = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_RD_LO = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_RD_HI = 4'hA;

  // Bit 1 = mode, bit 0 = run (positions are software-visible)
  typedef struct packed {
    logic periodic;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/itmr_ctrl_regs.sv
module itmr_ctrl_regs
  import itmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [CNT_W/2-1:0]   bus_wdata,
  input  logic                 oneshot_done,
  output ctrl_t                ctrl_q,
  output logic                 ctrl_wr,
  output logic                 start_rise,
  output logic [CNT_W-1:0]     load_val
);
  localparam int BUS_W = CNT_W / 2;

  ctrl_t ctrl_d;

  assign ctrl_wr    = bus_wr && (bus_addr == OFS_CTRL);
  assign start_rise = ctrl_wr && bus_wdata[0] && !ctrl_q.run;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) begin
      ctrl_d.run      = bus_wdata[0];
      ctrl_d.periodic = bus_wdata[1];
    end else if (oneshot_done) begin
      ctrl_d.run = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  // Reload halves: data-path registers, no reset, written by clock enable
  for (genvar h = 0; h < 2; h++) begin : g_half
    localparam logic [ADDR_W-1:0] HALF_OFS = OFS_LD_LO + ADDR_W'(2 * h);
    logic half_we;
    assign half_we = bus_wr && (bus_addr == HALF_OFS);
    always_ff @(posedge clk) begin
      if (half_we) load_val[h*BUS_W +: BUS_W] <= bus_wdata;
    end
  end

  assert_oneshot_clears_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    oneshot_done |=> !ctrl_q.run);
  assert_start_sets_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_rise |=> ctrl_q.run);
endmodule

// File: rtl/itmr_count_core.sv
module itmr_count_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             periodic,
  input  logic             ctrl_wr,
  input  logic             start_rise,
  input  logic             tick_en,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             oneshot_done,
  output logic             zero_evt
);
  logic [CNT_W-1:0] cnt_d;
  logic             step, at_zero, wrap;

  assign step         = run && tick_en && !ctrl_wr;
  assign at_zero      = (cnt_q == '0);
  assign wrap         = step && at_zero;
  assign oneshot_done = wrap && !periodic;

  always_comb begin
    cnt_d = cnt_q;
    if (start_rise)           cnt_d = load_val;
    else if (wrap && periodic) cnt_d = load_val;
    else if (step && !at_zero) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      zero_evt <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      zero_evt <= wrap;
    end
  end

  assert_load_on_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_rise |=> cnt_q == $past(load_val));
  assert_decrement_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick_en && !ctrl_wr && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  assert_hold_when_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start_rise) |=> $stable(cnt_q));
  assert_event_after_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zero_evt) |-> $past(cnt_q) == '0);
  assert_reload_periodic_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick_en && !ctrl_wr && periodic && cnt_q == '0) |=> cnt_q == $past(load_val));
endmodule

// File: rtl/itmr_readback.sv
module itmr_readback
  import itmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_rd,
  input  ctrl_t              ctrl_q,
  input  logic [CNT_W-1:0]   cnt_q,
  output logic [CNT_W/2-1:0] bus_rdata
);
  localparam int BUS_W = CNT_W / 2;

  logic [BUS_W-1:0] shadow_q, shadow_d;
  logic             rd_hi;

  assign rd_hi    = bus_rd && (bus_addr == OFS_RD_HI);
  assign shadow_d = rd_hi ? cnt_q[BUS_W-1:0] : shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shadow_q <= '0;
    else        shadow_q <= shadow_d;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        OFS_CTRL:  bus_rdata = {{(BUS_W-2){1'b0}}, ctrl_q};
        OFS_RD_LO: bus_rdata = shadow_q;
        OFS_RD_HI: bus_rdata = cnt_q[CNT_W-1:BUS_W];
        default:   bus_rdata = '0;
      endcase
    end
  end

  assert_capture_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi |=> shadow_q == $past(cnt_q[BUS_W-1:0]));
  assert_shadow_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hi |=> $stable(shadow_q));
endmodule

// File: rtl/itmr_interval_timer.sv
module itmr_interval_timer
  import itmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [CNT_W/2-1:0] bus_wdata,
  output logic [CNT_W/2-1:0] bus_rdata,
  input  logic               tick_en,
  output logic               zero_evt
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  ctrl_t            ctrl_q;
  logic             ctrl_wr, start_rise, oneshot_done;
  logic [CNT_W-1:0] load_val, cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  itmr_ctrl_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .oneshot_done(oneshot_done), .ctrl_q(ctrl_q),
    .ctrl_wr(ctrl_wr), .start_rise(start_rise), .load_val(load_val));

  itmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_int_n), .run(ctrl_q.run), .periodic(ctrl_q.periodic),
    .ctrl_wr(ctrl_wr), .start_rise(start_rise), .tick_en(tick_en),
    .load_val(load_val), .cnt_q(cnt_q), .oneshot_done(oneshot_done),
    .zero_evt(zero_evt));

  itmr_readback #(.CNT_W(CNT_W)) u_rdbk (
    .clk(clk), .rst_n(rst_int_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .ctrl_q(ctrl_q), .cnt_q(cnt_q), .bus_rdata(bus_rdata));
endmodule

// File: tb/tb_itmr_interval_timer.sv
module tb_itmr_interval_timer;
  localparam int CW = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, tick_en = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        zero_evt;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  // reference model state
  bit        m_run, m_per, m_zero;
  bit [31:0] m_load, m_cnt;
  bit [15:0] m_shadow;

  itmr_interval_timer #(.CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_en(tick_en), .zero_evt(zero_evt));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual cycle %0d expected < 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic bit [15:0] exp_rdata(bit [3:0] a, bit rd);
    if (!rd) return 16'h0;
    case (a)
      4'h0:    return {14'h0, m_per, m_run};
      4'h8:    return m_shadow;
      4'hA:    return m_cnt[31:16];
      default: return 16'h0;
    endcase
  endfunction

  // one bus cycle: drive, compare, advance the model
  task automatic step(string req, bit [3:0] a, bit wr, bit rd, bit [15:0] wd, bit tk);
    bit nz;
    @(negedge clk);
    bus_addr = a; bus_wr = wr; bus_rd = rd; bus_wdata = wd; tick_en = tk;
    #1;
    check({req, " rdata"}, {16'h0, bus_rdata}, {16'h0, exp_rdata(a, rd)});
    check("R6 zero_evt", {31'h0, zero_evt}, {31'h0, m_zero});
    nz = 0;
    if (rd && a == 4'hA) m_shadow = m_cnt[15:0];
    if (wr && a == 4'h0) begin
      if (wd[0] && !m_run) m_cnt = m_load;
      m_run = wd[0]; m_per = wd[1];
    end else if (m_run && tk) begin
      if (m_cnt == 0) begin
        nz = 1;
        if (m_per) m_cnt = m_load; else m_run = 0;
      end else m_cnt = m_cnt - 1;
    end
    if (wr && a == 4'h4) m_load[15:0]  = wd;
    if (wr && a == 4'h6) m_load[31:16] = wd;
    m_zero = nz;
  endtask

  task automatic idle(string req, int n, bit tk);
    for (int i = 0; i < n; i++) step(req, 4'h3, 0, 0, 16'h0, tk);
  endtask

  task automatic rd(string req, bit [3:0] a, bit tk);
    step(req, a, 0, 1, 16'h0, tk);
  endtask

  task automatic wr(string req, bit [3:0] a, bit [15:0] d, bit tk);
    step(req, a, 1, 0, d, tk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd("R1 ctrl", 4'h0, 1); rd("R1 hi", 4'hA, 1); rd("R1 lo", 4'h8, 1);
    // R3 load halves, no effect on count, reads return 0
    wr("R3", 4'h4, 16'h0002, 1); wr("R3", 4'h6, 16'h0001, 1);
    rd("R3 ld lo read", 4'h4, 1); rd("R3 ld hi read", 4'h6, 1); rd("R3 hi", 4'hA, 1);
    // R4 start, R2 ctrl readback
    wr("R4 start", 4'h0, 16'h0001, 1);
    rd("R2 ctrl", 4'h0, 0); rd("R4 hi", 4'hA, 0); rd("R4 lo", 4'h8, 0);
    // R5 cross the half boundary; R10 frozen low half
    idle("R5", 2, 1); idle("R5 no tick", 3, 0); idle("R5", 2, 1);
    rd("R10 hi", 4'hA, 1); idle("R10", 4, 1); rd("R10 lo frozen", 4'h8, 1);
    rd("R10 hi", 4'hA, 0); rd("R10 lo", 4'h8, 0);
    // R9 rewrite run while running: no reload
    wr("R9", 4'h0, 16'h0001, 1); rd("R9 hi", 4'hA, 1); rd("R9 lo", 4'h8, 1);
    // stop: count holds
    wr("R5 stop", 4'h0, 16'h0000, 1); idle("R5 held", 4, 1);
    rd("R5 hi", 4'hA, 1); rd("R5 lo", 4'h8, 1);
    // R7 one-shot to zero
    wr("R3", 4'h6, 16'h0000, 1); wr("R3", 4'h4, 16'h0004, 1);
    wr("R7 start", 4'h0, 16'h0001, 1); idle("R7", 8, 1);
    rd("R7 ctrl", 4'h0, 1); rd("R7 hi", 4'hA, 1); rd("R7 lo", 4'h8, 1);
    // R8 periodic
    wr("R8", 4'h4, 16'h0003, 0); wr("R8 start", 4'h0, 16'h0003, 1);
    idle("R8", 14, 1); rd("R8 ctrl", 4'h0, 1);
    idle("R8 gaps", 6, 0); idle("R8", 5, 1);
    // R8 reload of zero: consecutive events
    wr("R8", 4'h0, 16'h0000, 1); wr("R8", 4'h4, 16'h0000, 1);
    wr("R8 zero", 4'h0, 16'h0003, 1); idle("R8 zero", 5, 1);
    // R2 mode switch to one-shot while running
    wr("R2 mode", 4'h0, 16'h0001, 1); idle("R7", 3, 1); rd("R2 ctrl", 4'h0, 1);
    // R11 unmapped and no-strobe reads
    rd("R11 2", 4'h2, 1); rd("R11 C", 4'hC, 1); rd("R11 E", 4'hE, 1);
    step("R11 no rd", 4'h0, 0, 0, 16'h0, 1);
    idle("R1 tail", 3, 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule